// File: doc/BRIEF.md
# Multiplexed Bus Address/Data Demultiplexer

This block sits between an 8-bit processor and a memory and I/O system with 20 address bits. The processor shares its pins over time. During the first clock period of a bus cycle, the low eight pins carry address bits 7..0 and the top four pins carry address bits 19..16. Later in the cycle the low pins carry data and the top pins carry status. Address bits 15..8 have pins of their own.

The block holds a stable 20-bit address for the whole cycle. The address path is transparent while the address-latch enable is high. After the enable falls, the address path holds the captured value. The block also controls an 8-bit data transceiver. The transceiver is enabled by the active-low data enable, and its direction follows the transmit/receive select. Finally, the block decodes the read and write strobes with the I/O-or-memory select into four active-low command strobes for the memory and I/O devices.

The transceiver is modelled with separate in, out and output-enable signals on each side instead of a tri-state pin. An output enable that is low stands for a high-impedance side.

Top module: `bus_demux`

## Requirements
- R1: While `ale_i` is 1, `addr_o` equals {`ahi_i`, `amid_i`, `ad_i`} in the same cycle (transparent path).
- R2: While `ale_i` is 0, `addr_o` holds the value present at the last rising clock edge at which `ale_i` was 1.
- R3: Status values driven on `ahi_i` and data driven on `ad_i` after `ale_i` falls never reach `addr_o`.
- R4: When `den_n_i` is 1, `mem_d_oe_o` and `cpu_d_oe_o` are both 0, and both data outputs are 0.
- R5: When `den_n_i` is 0 and `dtr_i` is 0 (receive), `cpu_d_oe_o` is 1, `cpu_d_o` equals `mem_d_i`, and `mem_d_oe_o` is 0.
- R6: When `den_n_i` is 0 and `dtr_i` is 1 (transmit), `mem_d_oe_o` is 1, `mem_d_o` equals `ad_i`, and `cpu_d_oe_o` is 0.
- R7: `memr_n_o` is 0 exactly when `rd_n_i` is 0 and `iom_i` is 0. `memw_n_o` is 0 exactly when `wr_n_i` is 0 and `iom_i` is 0.
- R8: `ior_n_o` is 0 exactly when `rd_n_i` is 0 and `iom_i` is 1. `iow_n_o` is 0 exactly when `wr_n_i` is 0 and `iom_i` is 1.
- R9: While `rst_n` is 0, all four strobes are 1 and both output enables are 0. The held address clears to zero, so `addr_o` is 0 while `ale_i` is 0.
- R10: The non-multiplexed bits 15..8 are held with the rest of the address, so changes on `amid_i` after `ale_i` falls do not reach `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 8 | Shared pins: address 7..0 in the first period, data later |
| amid_i | input | 8 | Address bits 15..8 |
| ahi_i | input | 4 | Shared pins: address 19..16 in the first period, status later |
| ale_i | input | 1 | Address-latch enable, active high |
| den_n_i | input | 1 | Transceiver enable, active low |
| dtr_i | input | 1 | Transceiver direction: 1 transmit (write), 0 receive (read) |
| iom_i | input | 1 | Access select: 1 I/O, 0 memory |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| mem_d_i | input | 8 | Data from the memory/IO side |
| addr_o | output | 20 | Held system address |
| mem_d_o | output | 8 | Data driven toward the memory/IO side |
| mem_d_oe_o | output | 1 | Memory-side output enable |
| cpu_d_o | output | 8 | Data driven toward the processor |
| cpu_d_oe_o | output | 1 | Processor-side output enable |
| memr_n_o | output | 1 | Memory read command, active low |
| memw_n_o | output | 1 | Memory write command, active low |
| ior_n_o | output | 1 | I/O read command, active low |
| iow_n_o | output | 1 | I/O write command, active low |

## Verification
The cycle-level properties are checked at every clock edge. These cover the transparent address path, the held address when the enable stays low, and the capture of the last enabled value just after the enable falls. They also cover the transceiver being off whenever its enable is high, the direction agreeing with the select, and each strobe implying its own input combination. Other points need the bench's full bus cycles. These are the proof that a specific address survives status and data on the shared pins through periods two to four, that data passes through in each direction, and that all eight read/write/select combinations and all four transceiver control combinations give the computed outputs. The behaviour in the middle of a reset also needs the bench.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

  typedef struct packed {
    logic memr_n;
    logic memw_n;
    logic ior_n;
    logic iow_n;
  } strobes_t;

  // Command decode: a command is active only out of reset, with its
  // input strobe low and the access select matching its space.
  function automatic strobes_t decode_strobes(input logic live,
                                              input logic rd_n,
                                              input logic wr_n,
                                              input logic io_sel);
    strobes_t s;
    s.memr_n = ~(live & ~rd_n & ~io_sel);
    s.memw_n = ~(live & ~wr_n & ~io_sel);
    s.ior_n  = ~(live & ~rd_n &  io_sel);
    s.iow_n  = ~(live & ~wr_n &  io_sel);
    return s;
  endfunction

  // Width of address slice idx when total bits are cut into lanes of lane bits.
  function automatic int lane_width(input int total, input int lane, input int idx);
    int rem;
    rem = total - idx * lane;
    return (rem < lane) ? rem : lane;
  endfunction

endpackage

// File: rtl/bdx_addr_hold.sv
module bdx_addr_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (le_i) held_q <= d_i;
  end

  // Open while the enable is high, closed on the captured value otherwise.
  assign q_o = le_i ? d_i : held_q;
endmodule

// File: rtl/bdx_xcvr.sv
module bdx_xcvr #(
  parameter int DW = 8
) (
  input  logic          rst_n,
  input  logic          den_n_i,
  input  logic          dtr_i,
  input  logic [DW-1:0] cpu_side_i,
  input  logic [DW-1:0] mem_side_i,
  output logic          en_o,
  output logic [DW-1:0] mem_d_o,
  output logic          mem_d_oe_o,
  output logic [DW-1:0] cpu_d_o,
  output logic          cpu_d_oe_o
);
  logic to_mem, to_cpu;

  assign en_o       = rst_n & ~den_n_i;
  assign to_mem     = en_o & dtr_i;
  assign to_cpu     = en_o & ~dtr_i;
  assign mem_d_oe_o = to_mem;
  assign cpu_d_oe_o = to_cpu;
  assign mem_d_o    = to_mem ? cpu_side_i : '0;
  assign cpu_d_o    = to_cpu ? mem_side_i : '0;
endmodule

// File: rtl/bdx_strobe_dec.sv
module bdx_strobe_dec
  import bdx_pkg::*;
(
  input  logic     rst_n,
  input  logic     rd_n_i,
  input  logic     wr_n_i,
  input  logic     iom_i,
  output strobes_t strb_o
);
  always_comb strb_o = decode_strobes(rst_n, rd_n_i, wr_n_i, iom_i);
endmodule

// File: rtl/bus_demux.sv
module bus_demux
  import bdx_pkg::*;
#(
  parameter int AD_W   = 8,
  parameter int MID_W  = 8,
  parameter int HI_W   = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AD_W-1:0]             ad_i,
  input  logic [MID_W-1:0]            amid_i,
  input  logic [HI_W-1:0]             ahi_i,
  input  logic                        ale_i,
  input  logic                        den_n_i,
  input  logic                        dtr_i,
  input  logic                        iom_i,
  input  logic                        rd_n_i,
  input  logic                        wr_n_i,
  input  logic [AD_W-1:0]             mem_d_i,
  output logic [AD_W+MID_W+HI_W-1:0]  addr_o,
  output logic [AD_W-1:0]             mem_d_o,
  output logic                        mem_d_oe_o,
  output logic [AD_W-1:0]             cpu_d_o,
  output logic                        cpu_d_oe_o,
  output logic                        memr_n_o,
  output logic                        memw_n_o,
  output logic                        ior_n_o,
  output logic                        iow_n_o
);
  localparam int ADDR_W  = AD_W + MID_W + HI_W;
  localparam int N_LANES = (ADDR_W + LANE_W - 1) / LANE_W;

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] live_addr;
  logic              addr_capture;
  logic              xcvr_en;
  strobes_t          strb;

  assign live_addr    = {ahi_i, amid_i, ad_i};
  assign addr_capture = ale_i;

  // One hold stage per address lane, every lane on the same enable.
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    localparam int LW = lane_width(ADDR_W, LANE_W, g);
    bdx_addr_hold #(.W(LW)) i_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .le_i  (addr_capture),
      .d_i   (live_addr[LO +: LW]),
      .q_o   (addr_o[LO +: LW])
    );
  end

  bdx_xcvr #(.DW(AD_W)) i_xcvr (
    .rst_n      (rst_n),
    .den_n_i    (den_n_i),
    .dtr_i      (dtr_i),
    .cpu_side_i (ad_i),
    .mem_side_i (mem_d_i),
    .en_o       (xcvr_en),
    .mem_d_o    (mem_d_o),
    .mem_d_oe_o (mem_d_oe_o),
    .cpu_d_o    (cpu_d_o),
    .cpu_d_oe_o (cpu_d_oe_o)
  );

  bdx_strobe_dec i_dec (
    .rst_n  (rst_n),
    .rd_n_i (rd_n_i),
    .wr_n_i (wr_n_i),
    .iom_i  (iom_i),
    .strb_o (strb)
  );

  assign memr_n_o = strb.memr_n;
  assign memw_n_o = strb.memw_n;
  assign ior_n_o  = strb.ior_n;
  assign iow_n_o  = strb.iow_n;
endmodule

// File: rtl/bdx_chk.sv
module bdx_chk #(
  parameter int AD_W  = 8,
  parameter int MID_W = 8,
  parameter int HI_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AD_W-1:0]            ad_i,
  input logic [MID_W-1:0]           amid_i,
  input logic [HI_W-1:0]            ahi_i,
  input logic                       ale_i,
  input logic                       den_n_i,
  input logic                       dtr_i,
  input logic                       iom_i,
  input logic                       rd_n_i,
  input logic                       wr_n_i,
  input logic [AD_W+MID_W+HI_W-1:0] addr_o,
  input logic                       mem_d_oe_o,
  input logic                       cpu_d_oe_o,
  input logic                       memr_n_o,
  input logic                       memw_n_o,
  input logic                       ior_n_o,
  input logic                       iow_n_o,
  input logic                       xcvr_en
);
  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |-> addr_o == {ahi_i, amid_i, ad_i});

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && !$past(ale_i)) |-> $stable(addr_o));

  p_status_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && $past(ale_i)) |-> addr_o == $past({ahi_i, amid_i, ad_i}));

  p_xcvr_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (den_n_i || !xcvr_en) |-> (!mem_d_oe_o && !cpu_d_oe_o));

  p_receive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n_i && !dtr_i) |-> (cpu_d_oe_o && !mem_d_oe_o));

  p_transmit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n_i && dtr_i) |-> (mem_d_oe_o && !cpu_d_oe_o));

  p_memr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n_o |-> (!rd_n_i && !iom_i));

  p_memw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !memw_n_o |-> (!wr_n_i && !iom_i));

  p_ior_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n_o |-> (!rd_n_i && iom_i));

  p_iow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iow_n_o |-> (!wr_n_i && iom_i));

  p_read_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~memr_n_o, ~ior_n_o}));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> ({memr_n_o, memw_n_o, ior_n_o, iow_n_o} == 4'hF
                && !mem_d_oe_o && !cpu_d_oe_o));
endmodule

bind bus_demux bdx_chk #(.AD_W(AD_W), .MID_W(MID_W), .HI_W(HI_W)) i_chk (.*);

// File: tb/test_bus_demux.sv
module test_bus_demux;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ad, amid, mem_d;
  logic [3:0]  ahi;
  logic        ale, den_n, dtr, iom, rd_n, wr_n;
  logic [19:0] addr;
  logic [7:0]  mem_do, cpu_do;
  logic        mem_oe, cpu_oe, memr_n, memw_n, ior_n, iow_n;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bus_demux i_bus_demux (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .amid_i(amid), .ahi_i(ahi),
    .ale_i(ale), .den_n_i(den_n), .dtr_i(dtr), .iom_i(iom),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .mem_d_i(mem_d), .addr_o(addr),
    .mem_d_o(mem_do), .mem_d_oe_o(mem_oe), .cpu_d_o(cpu_do),
    .cpu_d_oe_o(cpu_oe), .memr_n_o(memr_n), .memw_n_o(memw_n),
    .ior_n_o(ior_n), .iow_n_o(iow_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected strobes {memr_n, memw_n, ior_n, iow_n}, stated per space.
  function automatic logic [3:0] exp_strb(input logic r_n, input logic w_n, input logic io);
    logic [3:0] e;
    e = 4'b1111;
    if (io) begin
      if (r_n == 1'b0) e[1] = 1'b0;
      if (w_n == 1'b0) e[0] = 1'b0;
    end else begin
      if (r_n == 1'b0) e[3] = 1'b0;
      if (w_n == 1'b0) e[2] = 1'b0;
    end
    return e;
  endfunction

  function automatic logic [3:0] strb_now();
    return {memr_n, memw_n, ior_n, iow_n};
  endfunction

  // One four-period bus cycle, checked in every period.
  task automatic bus_cycle(input logic [19:0] a, input logic io, input logic wr, input logic [7:0] d);
    // T1: address on the shared pins, enable high
    @(negedge clk);
    {ahi, amid, ad} = a;
    ale = 1'b1; iom = io; dtr = wr; den_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    mem_d = 8'h00;
    #2;
    chk("R1 transparent address", {12'h0, addr}, {12'h0, a});
    chk("R9 idle strobes in T1", {28'h0, strb_now()}, 32'hF);
    // T2, T3: status on top pins, data or junk on low pins, mid pins disturbed
    for (int t = 2; t <= 3; t++) begin
      @(negedge clk);
      ale = 1'b0;
      ahi = ~a[19:16] ^ 4'(t);
      amid = ~a[15:8];
      ad = wr ? d : (a[7:0] ^ 8'hA5);
      mem_d = wr ? 8'h3C : d;
      den_n = 1'b0;
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
      #2;
      chk("R3 R10 address held against status", {12'h0, addr}, {12'h0, a});
      chk(io ? "R8 io strobe" : "R7 mem strobe", {28'h0, strb_now()},
          {28'h0, exp_strb(rd_n, wr_n, io)});
      if (wr) begin
        chk("R6 transmit", {22'h0, mem_oe, cpu_oe, mem_do}, {22'h0, 1'b1, 1'b0, d});
      end else begin
        chk("R5 receive", {22'h0, mem_oe, cpu_oe, cpu_do}, {22'h0, 1'b0, 1'b1, d});
      end
    end
    // T4: strobes and transceiver released, address still held
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; den_n = 1'b1;
    #2;
    chk("R2 address held in T4", {12'h0, addr}, {12'h0, a});
    chk("R4 transceiver off in T4", {14'h0, mem_oe, cpu_oe, mem_do, cpu_do}, 32'h0);
    chk("R7 R8 strobes idle in T4", {28'h0, strb_now()}, 32'hF);
  endtask

  initial begin
    rst_n = 1'b0; ale = 1'b0; den_n = 1'b0; dtr = 1'b0; iom = 1'b0;
    rd_n = 1'b0; wr_n = 1'b0; ad = 8'h12; amid = 8'h34; ahi = 4'h5; mem_d = 8'h77;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset strobes", {28'h0, strb_now()}, 32'hF);
    chk("R9 reset enables", {30'h0, mem_oe, cpu_oe}, 32'h0);
    chk("R9 reset address", {12'h0, addr}, 32'h0);
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; den_n = 1'b1;
    rst_n = 1'b1;

    // Bus cycles over corner and spread addresses, all space/direction pairs.
    for (int i = 0; i < 48; i++) begin
      logic [19:0] a;
      case (i)
        0: a = 20'h00000;
        1: a = 20'hFFFFF;
        2: a = 20'hA0023;
        3: a = 20'h20023;
        4: a = 20'h7FFFF;
        5: a = 20'h80000;
        default: a = 20'(i * 32'h1F3A7 + 32'h00345);
      endcase
      bus_cycle(a, i[0], i[1], 8'(i * 37 + 11));
    end

    // Exhaustive strobe decode with the enable low.
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ale = 1'b0; den_n = 1'b1;
      {iom, rd_n, wr_n} = 3'(v);
      #2;
      chk(iom ? "R8 strobe sweep" : "R7 strobe sweep", {28'h0, strb_now()},
          {28'h0, exp_strb(rd_n, wr_n, iom)});
    end

    // Exhaustive transceiver control.
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      {den_n, dtr} = 2'(v);
      ad = 8'(8'hC3 + v); mem_d = 8'(8'h5A + v);
      #2;
      if (den_n) begin
        chk("R4 sweep off", {14'h0, mem_oe, cpu_oe, mem_do, cpu_do}, 32'h0);
      end else if (dtr) begin
        chk("R6 sweep transmit", {14'h0, mem_oe, cpu_oe, mem_do, cpu_do},
            {14'h0, 2'b10, ad, 8'h00});
      end else begin
        chk("R5 sweep receive", {14'h0, mem_oe, cpu_oe, mem_do, cpu_do},
            {14'h0, 2'b01, 8'h00, mem_d});
      end
    end

    // Reset in the middle of an active read.
    @(negedge clk);
    den_n = 1'b0; dtr = 1'b0; iom = 1'b0; rd_n = 1'b0; wr_n = 1'b1; ale = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R9 mid reset strobes", {28'h0, strb_now()}, 32'hF);
    chk("R9 mid reset enables", {30'h0, mem_oe, cpu_oe}, 32'h0);
    chk("R9 mid reset address", {12'h0, addr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R7 read resumes after reset", {28'h0, strb_now()}, 32'h7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule